// File: doc/BRIEF.md
# Clamped PWM Duty Generator with Calibration Window

This block turns a signed field sample into a fixed-frequency pulse-width-modulated line. A free-running tick counter sets the carrier period, and a 4-bit frequency trim chooses the period length. The duty cycle is a programmable quiescent level plus the field sample scaled by a programmable sensitivity. The duty is held as a fraction in units of 1/1024. It is clamped to a window well away from 0% and 100%, so a stuck-low or stuck-high line can be told apart from a valid reading. The fraction is converted to a tick count and latched once per carrier period.

A start-up calibration window can be enabled. While the window is open, every latched duty is the pure quiescent value and the field is ignored. The window lasts a fixed number of carrier periods, so its length in time follows the programmed carrier frequency. A flag reports when the window is open.

Top module: `clamped_pwm_gen`

## Requirements
- R1: While reset is held and during the first carrier period after reset release, `pwm_o` is low. The first period is 560 ticks long.
- R2: The period in ticks is 560 − 20·`ftrim_i`. Code 0 gives 560, code 7 gives 420 and code 15 gives 260. The counter restarts at each period boundary, and the new period length is sampled there.
- R3: The quiescent fraction is taken from `qtrim_i[8:0]`. When bit 8 is 0 it is 512 + `qtrim_i[7:0]`. When bit 8 is 1 it is 511 − `qtrim_i[7:0]`, so code 256 gives 511 and code 511 gives the minimum of 256.
- R4: The gain is `strim_i[7:0]` when `strim_i[8]` is 0, and twice `strim_i[7:0]` when it is 1. The duty offset is floor(`field_i`·gain / 1024), with `field_i` signed two's complement. The offset is added to the quiescent fraction.
- R5: The fraction is clamped to the window [82, 942]. The intermediate sum is wide enough that the extreme input combinations saturate at the clamp and never wrap.
- R6: The duty tick count is floor(fraction·period / 1024). `pwm_o` is high for exactly that many ticks at the start of each period and low for the rest.
- R7: All trim and field inputs are sampled only at a period boundary. A change in mid-period does not alter the running period.
- R8: When `cal_en_i` is 1, `cal_active_o` is high from reset release until the 50th period boundary, where it falls and stays low.
- R9: While `cal_active_o` is high, the duty latched at each boundary is the quiescent fraction alone and the field is ignored. The first boundary after the window closes uses the field again.
- R10: When `cal_en_i` is 0, `cal_active_o` stays low and the field affects the duty from the first latched period onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_i | input | 12 | Signed field sample |
| qtrim_i | input | 9 | Quiescent duty trim code |
| strim_i | input | 9 | Sensitivity trim: bit 8 selects the range, bits 7:0 the fine step |
| ftrim_i | input | 4 | Carrier period trim code |
| cal_en_i | input | 1 | Enables the start-up calibration window |
| pwm_o | output | 1 | PWM output line |
| cal_active_o | output | 1 | High while the calibration window is open |

## Verification
The duty path is driven with a vector table at a fixed period. The table holds zero field across several quiescent codes on both sides of the direction reversal, which separates the two decode branches. It holds small positive and negative fields, which expose the floor rounding of negative offsets, and it covers both sensitivity ranges. Full-scale fields with maximum gain push the sum to each clamp; a result that wrapped instead of saturating would show up far outside the window. Directed runs change the field in mid-period, move the frequency trim to change the period, and compare start-up with the calibration window enabled and disabled, including the exact cycle at which the flag drops.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  typedef enum logic {
    SENS_FINE   = 1'b0,
    SENS_COARSE = 1'b1
  } sens_range_e;
endpackage

// File: rtl/cpwm_carrier.sv
`timescale 1ns/1ps
module cpwm_carrier #(
  parameter int FTRIM_W     = 4,
  parameter int PERIOD_MAX  = 560,
  parameter int PERIOD_STEP = 20,
  localparam int PER_W      = $clog2(PERIOD_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FTRIM_W-1:0] ftrim_i,
  output logic [PER_W-1:0]   per_next_o,
  output logic [PER_W-1:0]   period_o,
  output logic [PER_W-1:0]   cnt_o,
  output logic               wrap_o
);
  logic [PER_W-1:0] cnt_q, period_q;

  assign per_next_o = PER_W'(PERIOD_MAX) - PER_W'(PERIOD_STEP) * PER_W'(ftrim_i);
  assign wrap_o     = (cnt_q == period_q - PER_W'(1));
  assign period_o   = period_q;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= PER_W'(PERIOD_MAX);
    end else if (wrap_o) begin
      cnt_q    <= '0;
      period_q <= per_next_o;
    end else begin
      cnt_q    <= cnt_q + PER_W'(1);
    end
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period_q); // R2
  AST_PERIOD_ONLY_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> $stable(period_q)); // R7
endmodule

// File: rtl/cpwm_duty_calc.sv
`timescale 1ns/1ps
module cpwm_duty_calc
  import cpwm_pkg::*;
#(
  parameter int FIELD_W    = 12,
  parameter int QTRIM_W    = 9,
  parameter int STRIM_W    = 9,
  parameter int FRAC_W     = 10,
  parameter int SENS_SHIFT = 10,
  parameter int CLAMP_LO   = 82,
  parameter int CLAMP_HI   = 942
) (
  input  logic signed [FIELD_W-1:0] field_i,
  input  logic [QTRIM_W-1:0]        qtrim_i,
  input  logic [STRIM_W-1:0]        strim_i,
  input  logic                      hold_q_i,
  output logic [FRAC_W-1:0]         frac_o
);
  localparam int QFINE_W = QTRIM_W - 1;
  localparam int FINE_W  = STRIM_W - 1;
  localparam int HALF    = 1 << (FRAC_W - 1);
  // product of signed field and non-negative gain, plus one bit of headroom for the add
  localparam int PROD_W  = FIELD_W + STRIM_W + 1;
  localparam int SUM_W   = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] LO_S = SUM_W'(CLAMP_LO);
  localparam logic signed [SUM_W-1:0] HI_S = SUM_W'(CLAMP_HI);

  sens_range_e              rng;
  logic [FRAC_W-1:0]        q_frac;
  logic [STRIM_W-1:0]       gain;
  logic signed [PROD_W-1:0] fld_x, gain_x, prod, delta;
  logic signed [SUM_W-1:0]  q_s, sum;

  // quiescent code reverses direction at its top bit
  assign q_frac = qtrim_i[QTRIM_W-1]
                ? FRAC_W'(HALF - 1) - FRAC_W'(qtrim_i[QFINE_W-1:0])
                : FRAC_W'(HALF)     + FRAC_W'(qtrim_i[QFINE_W-1:0]);

  assign rng  = sens_range_e'(strim_i[STRIM_W-1]);
  assign gain = (rng == SENS_COARSE) ? {strim_i[FINE_W-1:0], 1'b0}
                                     : {1'b0, strim_i[FINE_W-1:0]};

  assign fld_x  = PROD_W'(field_i);
  assign gain_x = PROD_W'($signed({1'b0, gain}));
  assign prod   = fld_x * gain_x;
  assign delta  = prod >>> SENS_SHIFT;
  assign q_s    = SUM_W'($signed({1'b0, q_frac}));
  assign sum    = hold_q_i ? q_s : q_s + SUM_W'(delta);

  always_comb begin
    if (sum < LO_S)      frac_o = FRAC_W'(CLAMP_LO);
    else if (sum > HI_S) frac_o = FRAC_W'(CLAMP_HI);
    else                 frac_o = FRAC_W'(sum);
  end
endmodule

// File: rtl/cpwm_cal_window.sv
`timescale 1ns/1ps
module cpwm_cal_window #(
  parameter int CAL_PERIODS = 50,
  localparam int CW         = $clog2(CAL_PERIODS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic cal_en_i,
  output logic active_o
);
  logic [CW-1:0] cnt_q;
  logic          win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      win_q <= 1'b1;
    end else if (wrap_i && win_q) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(CAL_PERIODS - 1)) win_q <= 1'b0;
    end
  end

  assign active_o = win_q & cal_en_i;

  AST_WINDOW_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_q |=> !win_q); // R8
  AST_WINDOW_CLOSES_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(win_q) |-> $past(wrap_i)); // R8
  AST_WINDOW_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q |-> cnt_q < CW'(CAL_PERIODS)); // R8
endmodule

// File: rtl/clamped_pwm_gen.sv
`timescale 1ns/1ps
module clamped_pwm_gen #(
  parameter int FIELD_W     = 12,
  parameter int QTRIM_W     = 9,
  parameter int STRIM_W     = 9,
  parameter int FTRIM_W     = 4,
  parameter int FRAC_W      = 10,
  parameter int SENS_SHIFT  = 10,
  parameter int CLAMP_LO    = 82,
  parameter int CLAMP_HI    = 942,
  parameter int PERIOD_MAX  = 560,
  parameter int PERIOD_STEP = 20,
  parameter int CAL_PERIODS = 50
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic signed [FIELD_W-1:0] field_i,
  input  logic [QTRIM_W-1:0]        qtrim_i,
  input  logic [STRIM_W-1:0]        strim_i,
  input  logic [FTRIM_W-1:0]        ftrim_i,
  input  logic                      cal_en_i,
  output logic                      pwm_o,
  output logic                      cal_active_o
);
  localparam int PER_W  = $clog2(PERIOD_MAX + 1);
  localparam int SCL_W  = FRAC_W + PER_W;

  logic [PER_W-1:0]  per_next, period, cnt, ticks_next, duty_ticks_q;
  logic              wrap;
  logic [FRAC_W-1:0] frac;
  logic [SCL_W-1:0]  scaled;

  cpwm_carrier #(
    .FTRIM_W(FTRIM_W), .PERIOD_MAX(PERIOD_MAX), .PERIOD_STEP(PERIOD_STEP)
  ) u_carrier (
    .clk_i(clk_i), .rst_ni(rst_ni), .ftrim_i(ftrim_i),
    .per_next_o(per_next), .period_o(period), .cnt_o(cnt), .wrap_o(wrap)
  );

  cpwm_duty_calc #(
    .FIELD_W(FIELD_W), .QTRIM_W(QTRIM_W), .STRIM_W(STRIM_W), .FRAC_W(FRAC_W),
    .SENS_SHIFT(SENS_SHIFT), .CLAMP_LO(CLAMP_LO), .CLAMP_HI(CLAMP_HI)
  ) u_calc (
    .field_i(field_i), .qtrim_i(qtrim_i), .strim_i(strim_i),
    .hold_q_i(cal_active_o), .frac_o(frac)
  );

  cpwm_cal_window #(.CAL_PERIODS(CAL_PERIODS)) u_cal (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .cal_en_i(cal_en_i),
    .active_o(cal_active_o)
  );

  // duty ticks for the period about to start, using that period's length
  assign scaled     = SCL_W'(frac) * SCL_W'(per_next);
  assign ticks_next = PER_W'(scaled >> FRAC_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   duty_ticks_q <= '0;
    else if (wrap) duty_ticks_q <= ticks_next;
  end

  assign pwm_o = (cnt < duty_ticks_q);

  AST_FRAC_IN_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac >= FRAC_W'(CLAMP_LO)) && (frac <= FRAC_W'(CLAMP_HI))); // R5
  AST_TICKS_BELOW_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_ticks_q < period); // R6
  AST_DUTY_ONLY_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(duty_ticks_q)); // R7
endmodule

// File: tb/clamped_pwm_gen_test.sv
`timescale 1ns/1ps
module clamped_pwm_gen_test;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [11:0] field = '0;
  logic [8:0]         qtrim = '0;
  logic [8:0]         strim = '0;
  logic [3:0]         ftrim = '0;
  logic               cal_en = 1'b1;
  logic               pwm, cal_act;

  int n_total = 0;
  int n_fail  = 0;
  int cal_cnt = 0;

  always #2.5 clk = ~clk;

  clamped_pwm_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .field_i(field), .qtrim_i(qtrim),
    .strim_i(strim), .ftrim_i(ftrim), .cal_en_i(cal_en),
    .pwm_o(pwm), .cal_active_o(cal_act)
  );

  // field, quiescent code, sensitivity code, expected high ticks at a 560-tick period
  localparam int NV = 10;
  localparam int VF[NV] = '{0,   0,   0,   0, 100, -100, 100, 2047, -2048, 1000};
  localparam int VQ[NV] = '{0, 100, 300, 511,   0,    0,   0,  255,   511,    0};
  localparam int VS[NV] = '{0,   0,   0,   0, 100,  100, 356,  511,   511,  200};
  localparam int VT[NV] = '{280, 334, 255, 140, 284, 274, 290, 515,  44,   386};

  always @(negedge clk) if (rst_ni && cal_act) cal_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = pwm;
    forever begin
      @(negedge clk);
      if (pwm && !p) break;
      p = pwm;
    end
  endtask

  // call right after a rise; returns at the next rise
  task automatic measure(output int hi, output int per);
    logic p;
    hi = 0; per = 0;
    do begin
      hi += int'(pwm); per++; p = pwm;
      @(negedge clk);
    end while (!(pwm && !p));
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_total++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int hi, per;
    logic p;
    // R1 reset state, calibration enabled
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pwm low in reset", int'(pwm), 0);
    chk("R8 flag high in reset with cal enabled", int'(cal_act), 1);
    field = 12'sd2047; strim = 9'd511; qtrim = '0;
    @(posedge clk); #1 rst_ni = 1'b1;

    // R9 field ignored while window open
    wait_rise(); measure(hi, per);
    chk("R9 quiescent duty during window", hi, 280);
    chk("R2 period code 0", per, 560);
    while (cal_act) @(negedge clk);
    chk("R8 window length in ticks", cal_cnt, 50 * 560);
    wait_rise(); measure(hi, per);
    chk("R9 field applies after window", hi, 515);

    // R10 calibration disabled
    rst_ni = 1'b0; cal_en = 1'b0; field = 12'sd100; strim = 9'd100;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 flag low in reset", int'(cal_act), 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    hi = 0;
    repeat (560) begin @(negedge clk); hi += int'(pwm); end
    chk("R1 first period low", hi, 0);
    @(negedge clk);
    chk("R6 rise at second period start", int'(pwm), 1);
    chk("R10 flag low after release", int'(cal_act), 0);
    measure(hi, per);
    chk("R10 field used in first latched period", hi, 284);

    // R3 R4 R5 table
    for (int i = 0; i < NV; i++) begin
      field = 12'(VF[i]); qtrim = 9'(VQ[i]); strim = 9'(VS[i]);
      wait_rise(); measure(hi, per);
      chk($sformatf("R3/R4/R5 vector %0d", i), hi, VT[i]);
      chk($sformatf("R2 period vector %0d", i), per, 560);
    end

    // R7 mid-period change does not touch the running period
    field = '0; qtrim = '0; strim = '0;
    wait_rise(); measure(hi, per);
    chk("R7 baseline", hi, 280);
    hi = 0; per = 0;
    do begin
      hi += int'(pwm); per++; p = pwm;
      if (per == 5) begin field = 12'sd2047; strim = 9'd511; end
      @(negedge clk);
    end while (!(pwm && !p));
    chk("R7 running period unchanged", hi, 280);
    measure(hi, per);
    chk("R7 change applied next period", hi, 515);

    // R2 R6 frequency trim
    field = '0; strim = '0; ftrim = 4'd15;
    wait_rise(); measure(hi, per);
    chk("R2 period code 15", per, 260);
    chk("R6 half duty code 15", hi, 130);
    ftrim = 4'd7;
    wait_rise(); measure(hi, per);
    chk("R2 period code 7", per, 420);
    chk("R6 half duty code 7", hi, 210);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule